// File: doc/BRIEF.md
# Triggered Reload Timer

A down-counting timer for a microcontroller peripheral slot. Software programs a period value, then starts the timer by a trigger. The trigger is either a write of the start bit or an edge on an external trigger pin. One clock after the trigger is accepted, the period value is copied into the counter. From then on the counter steps down by one on every cycle in which the count-clock enable input is high.

When the counter sits at zero and one more count-clock enable arrives, an underflow event is recorded. In continuous mode the period is reloaded at that point and counting goes on. In one-shot mode the counter stays at zero and the timer waits for a new trigger.

Two sticky status flags record trigger acceptance and underflow. Software clears a flag by writing 0 to it; writing 1 leaves it unchanged. Each flag drives its own interrupt line when its enable bit is set. Software reaches the block through a small word-wide register port with a write strobe and a combinational read mux.

Register map: address 0 is control, address 1 is status, address 2 is the period, and address 3 is the counter (read only).

Top module: `rt_reload_timer`

## Requirements
- R1: After reset, every register reads 0 (control, status, period, counter) and both interrupt outputs are low.
- R2: An accepted trigger leaves the counter unchanged at the next clock edge. The counter holds the period value after the clock edge that follows.
- R3: A trigger is accepted only if one of two conditions holds. Either the run bit (control bit 0) is already set, or the write sets run and start (control bit 1) together. Otherwise it has no effect on the counter or on the flags. Control bit 1 always reads 0.
- R4: While counting, each cycle with cnt_en high lowers the counter by one. A cnt_en in the cycle where the period is being loaded is ignored.
- R5: Writing 0 to the run bit freezes the counter and cancels a pending load.
- R6: When the counter is 0, the next cnt_en sets the underflow flag (status bit 0). In continuous mode (control bit 2 = 0), the same edge reloads the period.
- R7: In one-shot mode (control bit 2 = 1), an underflow leaves the counter at 0 and stops counting. Further cnt_en pulses change nothing.
- R8: The mode bit and the edge field (control bits 4:3) accept writes only while run is 0, which includes the write that sets run. While running, writes to them are ignored.
- R9: Accepting a trigger sets the trigger flag (status bit 1). Writing 0 to a flag clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R10: irq_udf is high exactly when the underflow flag and its enable (status bit 2) are both set. irq_trg is high exactly when the trigger flag and its enable (status bit 3) are both set.
- R11: The external trigger, after an input synchroniser of EXT_SYNC stages, is accepted while running on the edges selected by control bits 4:3: bit 3 selects rising edges and bit 4 selects falling edges.
- R12: A trigger accepted while the counter is already running reloads the period one cycle later, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable, one decrement per high cycle |
| ext_trig | input | 1 | External trigger level, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| irq_udf | output | 1 | Underflow interrupt |
| irq_trg | output | 1 | Trigger interrupt |

## Verification
The assertions assume that bus_addr and bus_wdata are stable and meaningful whenever bus_wr is high. They also assume cnt_en is a plain one-cycle-granular enable that needs no synchronisation. Finally, they assume ext_trig may change at any time, because it only reaches the logic through the synchroniser. The stimulus drives every input at the falling clock edge and holds each write for exactly one cycle. It changes ext_trig only while no write is in flight, so each check lands on a cycle that can be worked out from R2 and R11.

// File: rtl/rt_pkg.sv
// Shared constants of the reload timer: register addresses and bit positions.
// Assumes a two-bit register address and a data word of at least 6 bits.
package rt_pkg;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STAT   = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;
    localparam logic [1:0] ADDR_COUNT  = 2'd3;

    // control word bit positions
    localparam int CB_RUN    = 0;
    localparam int CB_START  = 1;
    localparam int CB_ONCE   = 2;
    localparam int CB_ERISE  = 3;
    localparam int CB_EFALL  = 4;

    // status word bit positions
    localparam int SB_UDF    = 0;
    localparam int SB_TRG    = 1;
    localparam int SB_UDF_IE = 2;
    localparam int SB_TRG_IE = 3;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;
endpackage

// File: rtl/rt_regs.sv
// Register file of the reload timer: control, status and period registers,
// plus the read mux. It produces the next run state so the counter can react
// to a stop in the same cycle as the write. Assumes single-cycle write strobes.
module rt_regs
    import rt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             udf_set,
    input  logic             trg_set,
    input  logic [CNT_W-1:0] count_q,
    output logic             run_q,
    output logic             run_nxt,
    output logic             sw_start,
    output logic             once_q,
    output edge_sel_t        edge_q,
    output logic [CNT_W-1:0] period_q,
    output logic             udf_flag,
    output logic             trg_flag,
    output logic             udf_ie,
    output logic             trg_ie
);
    logic ctrl_wr, stat_wr, period_wr, mode_wr;

    // decode the write strobe per register
    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
        stat_wr   = bus_wr && (bus_addr == ADDR_STAT);
        period_wr = bus_wr && (bus_addr == ADDR_PERIOD);
        mode_wr   = ctrl_wr && !run_q;
        run_nxt   = ctrl_wr ? bus_wdata[CB_RUN] : run_q;
        sw_start  = ctrl_wr && bus_wdata[CB_RUN] && bus_wdata[CB_START];
    end

    // control register: run bit always writable, mode fields only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            once_q <= 1'b0;
            edge_q <= EDGE_NONE;
        end else begin
            run_q <= run_nxt;
            if (mode_wr) begin
                once_q <= bus_wdata[CB_ONCE];
                edge_q <= edge_sel_t'({bus_wdata[CB_EFALL], bus_wdata[CB_ERISE]});
            end
        end
    end

    // period register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (period_wr) begin
            period_q <= bus_wdata;
        end
    end

    // status flags: write 0 clears, write 1 keeps, hardware set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            udf_flag <= 1'b0;
            trg_flag <= 1'b0;
            udf_ie   <= 1'b0;
            trg_ie   <= 1'b0;
        end else begin
            udf_flag <= (udf_flag && !(stat_wr && !bus_wdata[SB_UDF])) || udf_set;
            trg_flag <= (trg_flag && !(stat_wr && !bus_wdata[SB_TRG])) || trg_set;
            if (stat_wr) begin
                udf_ie <= bus_wdata[SB_UDF_IE];
                trg_ie <= bus_wdata[SB_TRG_IE];
            end
        end
    end

    // read mux; the start bit always reads back as zero
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CB_RUN]   = run_q;
                bus_rdata[CB_ONCE]  = once_q;
                bus_rdata[CB_ERISE] = edge_q[0];
                bus_rdata[CB_EFALL] = edge_q[1];
            end
            ADDR_STAT: begin
                bus_rdata[SB_UDF]    = udf_flag;
                bus_rdata[SB_TRG]    = trg_flag;
                bus_rdata[SB_UDF_IE] = udf_ie;
                bus_rdata[SB_TRG_IE] = trg_ie;
            end
            ADDR_PERIOD: bus_rdata = period_q;
            ADDR_COUNT:  bus_rdata = count_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rt_trig.sv
// Trigger unit: synchronises the external trigger, detects the selected
// edges, merges them with the software start and keeps the one-cycle pending
// load request. Assumes ext_trig is asynchronous to clk.
module rt_trig
    import rt_pkg::*;
#(
    parameter int EXT_SYNC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ext_trig,
    input  edge_sel_t edge_q,
    input  logic      run_q,
    input  logic      run_nxt,
    input  logic      sw_start,
    output logic      accept,
    output logic      pend_q
);
    logic ext_s, ext_prev, ext_hit;

    // optional synchroniser chain selected by EXT_SYNC
    generate
        if (EXT_SYNC == 0) begin : g_nosync
            assign ext_s = ext_trig;
        end else begin : g_sync
            logic [EXT_SYNC-1:0] chain;
            // shift the external level through the synchroniser
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[EXT_SYNC-2+((EXT_SYNC==1)?1:0):0], ext_trig};
            end
            assign ext_s = chain[EXT_SYNC-1];
        end
    endgenerate

    // remember the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_s;
    end

    // edge qualification and trigger acceptance
    always_comb begin
        ext_hit = run_q && ((edge_q[0] && ext_s && !ext_prev) ||
                            (edge_q[1] && !ext_s && ext_prev));
        accept  = run_nxt && (sw_start || ext_hit);
    end

    // pending load request, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= accept;
    end
endmodule

// File: rtl/rt_count.sv
// Down counter: loads the period on a pending request, decrements on each
// count enable while active, flags underflow and reloads or stops by mode.
// Assumes run_nxt already reflects a same-cycle stop write.
module rt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_nxt,
    input  logic             load,
    input  logic             cnt_en,
    input  logic             once,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count_q,
    output logic             active_q,
    output logic             udf_set
);
    logic step, at_zero;

    // qualify a counting step and an underflow
    always_comb begin
        step    = run_nxt && !load && active_q && cnt_en;
        at_zero = (count_q == '0);
        udf_set = step && at_zero;
    end

    // counter and active state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            active_q <= 1'b0;
        end else if (!run_nxt) begin
            active_q <= 1'b0;
        end else if (load) begin
            count_q  <= period;
            active_q <= 1'b1;
        end else if (udf_set) begin
            if (once) begin
                active_q <= 1'b0;
            end else begin
                count_q <= period;
            end
        end else if (step) begin
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/rt_reload_timer.sv
// Top of the triggered reload timer: wires the register file, trigger unit
// and down counter, and forms the two interrupt lines.
// Assumes CNT_W >= 6 so the control and status fields fit the data word.
module rt_reload_timer
    import rt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int EXT_SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             ext_trig,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_udf,
    output logic             irq_trg
);
    logic             run_q, run_nxt, sw_start, once_q;
    edge_sel_t        edge_q;
    logic [CNT_W-1:0] period_q, count_q;
    logic             udf_flag, trg_flag, udf_ie, trg_ie;
    logic             accept, pend_q, active_q, udf_set;

    rt_regs #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .udf_set(udf_set),
        .trg_set(accept), .count_q(count_q), .run_q(run_q), .run_nxt(run_nxt),
        .sw_start(sw_start), .once_q(once_q), .edge_q(edge_q),
        .period_q(period_q), .udf_flag(udf_flag), .trg_flag(trg_flag),
        .udf_ie(udf_ie), .trg_ie(trg_ie)
    );

    rt_trig #(.EXT_SYNC(EXT_SYNC)) i_trig (
        .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .edge_q(edge_q),
        .run_q(run_q), .run_nxt(run_nxt), .sw_start(sw_start),
        .accept(accept), .pend_q(pend_q)
    );

    rt_count #(.CNT_W(CNT_W)) i_count (
        .clk(clk), .rst_n(rst_n), .run_nxt(run_nxt), .load(pend_q),
        .cnt_en(cnt_en), .once(once_q), .period(period_q),
        .count_q(count_q), .active_q(active_q), .udf_set(udf_set)
    );

    // interrupt lines gated by their enables
    always_comb begin
        irq_udf = udf_flag && udf_ie;
        irq_trg = trg_flag && trg_ie;
    end
endmodule

// File: rtl/rt_reload_timer_chk.sv
// Checker for the reload timer, bound to the top. Relates register writes,
// the pending load and the counter across cycles.
module rt_reload_timer_chk
    import rt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] bus_rdata,
    input logic             cnt_en,
    input logic [CNT_W-1:0] count_q,
    input logic             active_q,
    input logic             pend_q,
    input logic             run_q,
    input logic             run_nxt,
    input logic             udf_flag,
    input logic             udf_set,
    input logic [CNT_W-1:0] period_q
);
    // R2
    load_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && run_nxt) |=> (count_q == $past(period_q)));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && run_nxt && !pend_q && cnt_en && count_q != '0)
        |=> (count_q == $past(count_q) - 1'b1));

    // R5
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(count_q));

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !pend_q) |=> $stable(count_q));

    // R3
    start_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> !bus_rdata[CB_START]);

    // R9
    udf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_STAT && !bus_wdata[SB_UDF] && !udf_set)
        |=> !udf_flag);
endmodule

bind rt_reload_timer rt_reload_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
    .count_q(count_q), .active_q(active_q), .pend_q(pend_q), .run_q(run_q),
    .run_nxt(run_nxt), .udf_flag(udf_flag), .udf_set(udf_set),
    .period_q(period_q)
);

// File: tb/test_rt_reload_timer.sv
// Scoreboard bench: check tasks queue expected items, a monitor pops and
// compares them against the register read port or the interrupt pins.
module test_rt_reload_timer;
    localparam int W = 16;
    localparam logic [W-1:0] RUN = 16'h0001, STR = 16'h0002, ONE = 16'h0004,
                             ERS = 16'h0008, EFL = 16'h0010;

    logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, ext_trig = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0, bus_rdata;
    logic irq_udf, irq_trg;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0..3 register address, 4 = interrupt pins
        logic [W-1:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    rt_reload_timer #(.CNT_W(W), .EXT_SYNC(2)) i_rt_reload_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_trig(ext_trig),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_udf(irq_udf), .irq_trg(irq_trg)
    );

    // monitor: pop each expected item and compare with the observed value
    initial begin
        forever begin
            item_t it;
            logic [W-1:0] act;
            wait (sb.size() != 0);
            #1;
            it = sb.pop_front();
            act = (it.kind == 4) ? {{(W-2){1'b0}}, irq_trg, irq_udf} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic chk(input int kind, input logic [W-1:0] exp, input string req);
        item_t it;
        if (kind < 4) bus_addr = kind[1:0];
        it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_en = 1'b1;
            @(negedge clk); cnt_en = 1'b0;
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 16'h0000, "R1"); chk(1, 16'h0000, "R1"); chk(2, 16'h0000, "R1");
        chk(3, 16'h0000, "R1"); chk(4, 16'h0000, "R1");

        // R3 start without run is ignored
        wr(2'd2, 16'd5);
        wr(2'd0, STR);
        chk(3, 16'd0, "R3"); chk(1, 16'h0000, "R3");
        cyc(1);
        chk(3, 16'd0, "R3");

        // R2 enabling start: load one cycle later
        wr(2'd0, RUN | STR);
        chk(3, 16'd0, "R2"); chk(1, 16'h0002, "R9"); chk(0, 16'h0001, "R3");
        cyc(1);
        chk(3, 16'd5, "R2");

        // R4 decrement, R6 continuous underflow reload
        tick(2); chk(3, 16'd3, "R4");
        tick(3); chk(3, 16'd0, "R4");
        tick(1); chk(3, 16'd5, "R6"); chk(1, 16'h0003, "R6");

        // R9 write 1 keeps flags, R10 interrupts follow enables
        wr(2'd1, 16'h000F); chk(1, 16'h000F, "R9"); chk(4, 16'h0003, "R10");
        wr(2'd1, 16'h0004); chk(1, 16'h0004, "R9"); chk(4, 16'h0000, "R10");

        // R8 mode write while running is ignored
        wr(2'd0, RUN | ONE | ERS | EFL); chk(0, 16'h0001, "R8");

        // R12 retrigger while counting
        tick(2); chk(3, 16'd3, "R12");
        wr(2'd0, RUN | STR); chk(3, 16'd3, "R12");
        cyc(1); chk(3, 16'd5, "R12"); chk(1, 16'h0006, "R9");

        // R5 stop freezes
        wr(2'd0, 16'h0000);
        tick(2); chk(3, 16'd5, "R5"); chk(0, 16'h0000, "R5");
        wr(2'd1, 16'h0000); chk(1, 16'h0000, "R9");

        // R7 one-shot, mode taken in the enabling write (R8)
        wr(2'd0, RUN | STR | ONE);
        cyc(1); chk(3, 16'd5, "R2"); chk(0, 16'h0005, "R8");
        tick(5); chk(3, 16'd0, "R7"); chk(1, 16'h0002, "R7");
        tick(1); chk(3, 16'd0, "R7"); chk(1, 16'h0003, "R6");
        tick(2); chk(3, 16'd0, "R7");
        wr(2'd1, 16'h0000); tick(1); chk(1, 16'h0000, "R7");

        // R11 external rising edge
        wr(2'd2, 16'd9);
        wr(2'd0, 16'h0000);
        wr(2'd0, RUN | ERS); chk(0, 16'h0009, "R11");
        wr(2'd1, 16'h0008);
        @(negedge clk); ext_trig = 1'b1;
        cyc(3);
        chk(1, 16'h000A, "R11"); chk(3, 16'd0, "R2"); chk(4, 16'h0002, "R10");
        cyc(1); chk(3, 16'd9, "R11");
        wr(2'd1, 16'h0008); chk(1, 16'h0008, "R9");
        // R11 falling edge not selected
        @(negedge clk); ext_trig = 1'b0;
        cyc(5); chk(1, 16'h0008, "R11"); chk(3, 16'd9, "R11");
        // R3 external edge while stopped is ignored
        wr(2'd0, 16'h0000);
        @(negedge clk); ext_trig = 1'b1;
        cyc(5); chk(1, 16'h0008, "R3"); chk(3, 16'd9, "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule